// File: doc/BRIEF.md
# Lot Occupancy Counter with Status Display

This block keeps a running count of vehicles in a lot with a fixed number of spaces. Single-cycle pulses on `inc` and `dec` come from an upstream direction detector. The count stays between zero and the capacity set by the `CAPACITY` parameter. The block is built and checked at both 25 and 5.

The count is shown in decimal on the two lowest of six seven-segment digits. The upper digits carry a word when the lot is at either limit: the word FULL when every space is taken, and the word CLEAR when the lot is empty. Two LED outputs repeat the raw states of the two gate sensors, so an operator can see the beams being broken.

The reset input is asynchronous and active-low. Its release is passed through a two-flop synchronizer before the counter leaves reset.

Top module: `lot_occupancy_display`

## Requirements
- R1: On a rising clock edge, `inc` high with `dec` low adds one to the count if it is below capacity. `dec` high with `inc` low subtracts one if the count is above zero. The display reflects the new count right after that edge.
- R2: The count saturates at both ends. An `inc` at capacity and a `dec` at zero each leave the count unchanged.
- R3: Segment bus bit 0 drives segment a, bit 1 drives b, and so on up to bit 6, which drives g. A segment is lit when its bit is 0.
  - Decimal digits use the usual shapes. For example, 0 lights a,b,c,d,e,f and 1 lights b,c.
  - When the count is strictly between zero and capacity, `hex0` shows the units and `hex1` shows the tens. `hex1` is blank (7'h7F) when the tens digit is 0, and `hex5` to `hex2` are blank.
- R4: When `inc` and `dec` are both high in the same cycle, the count is unchanged.
- R5: When the count equals capacity, `hex5`, `hex4`, `hex3` and `hex2` show F (a,e,f,g), U (b,c,d,e,f), L (d,e,f) and L. `hex1` and `hex0` keep showing the count as in R3.
- R6: When the count is zero:
  - `hex5` shows C (a,d,e,f) and `hex4` shows L.
  - `hex3` shows E (a,d,e,f,g) and `hex2` shows A (a,b,c,e,f,g).
  - `hex1` shows a lower-case r (e,g).
  - `hex0` shows the digit 0.
- R7: `led_left` equals `sens_a` and `led_right` equals `sens_b` at all times, with no clock delay.
- R8: While `rst_n` is low, the count is zero and the display shows the R6 pattern immediately, without waiting for a clock edge. After `rst_n` rises, counting resumes once two rising clock edges have passed.
- R9: `CAPACITY` may be any value from 1 to 99. With `CAPACITY` = 5, FULL appears at a count of 5 and `hex1` stays blank above zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inc | input | 1 | One-cycle pulse: a vehicle has entered |
| dec | input | 1 | One-cycle pulse: a vehicle has left |
| sens_a | input | 1 | Raw state of the outer gate sensor |
| sens_b | input | 1 | Raw state of the inner gate sensor |
| hex0 | output | 7 | Units digit, active-low segments |
| hex1 | output | 7 | Tens digit, or r of CLEAR |
| hex2 | output | 7 | Blank, L of FULL, or A of CLEAR |
| hex3 | output | 7 | Blank, L of FULL, or E of CLEAR |
| hex4 | output | 7 | Blank, U of FULL, or L of CLEAR |
| hex5 | output | 7 | Blank, F of FULL, or C of CLEAR |
| led_left | output | 1 | Follows sens_a |
| led_right | output | 1 | Follows sens_b |

## Verification
The states hardest to reach from the ports are the full boundary at a capacity of 25 and what happens there. This covers the clamp against further entries and simultaneous pulses arriving while the count sits at capacity. Uniform random pulses rarely wander that far from zero.

The stimulus therefore alternates biased phases: a long run with entries favoured, then one with exits favoured. Directed runs push straight past each limit and apply both pulses at zero, at capacity and in between.

A capacity-5 copy runs alongside the default copy on the same inputs. This exercises the single-digit variant and its FULL boundary many times per run.

// File: rtl/occ_pkg.sv
`timescale 1ns/1ps
package occ_pkg;

  typedef logic [6:0] seg_t;

  // Active-low glyphs, bit 0 = segment a ... bit 6 = segment g
  localparam seg_t GLYPH_BLANK = 7'h7F;
  localparam seg_t GLYPH_F     = ~7'h71;
  localparam seg_t GLYPH_U     = ~7'h3E;
  localparam seg_t GLYPH_L     = ~7'h38;
  localparam seg_t GLYPH_C     = ~7'h39;
  localparam seg_t GLYPH_E     = ~7'h79;
  localparam seg_t GLYPH_A     = ~7'h77;
  localparam seg_t GLYPH_R     = ~7'h50;

  function automatic seg_t digit_glyph(input logic [3:0] d);
    logic [6:0] lit;
    case (d)
      4'd0:    lit = 7'h3F;
      4'd1:    lit = 7'h06;
      4'd2:    lit = 7'h5B;
      4'd3:    lit = 7'h4F;
      4'd4:    lit = 7'h66;
      4'd5:    lit = 7'h6D;
      4'd6:    lit = 7'h7D;
      4'd7:    lit = 7'h07;
      4'd8:    lit = 7'h7F;
      4'd9:    lit = 7'h6F;
      default: lit = 7'h00;
    endcase
    return ~lit;
  endfunction

endpackage

// File: rtl/occ_rst_sync.sv
`timescale 1ns/1ps
module occ_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/occ_counter.sv
`timescale 1ns/1ps
module occ_counter #(
  parameter int CAPACITY = 25,
  parameter int CNT_W    = $clog2(CAPACITY + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);

  logic             step_up;
  logic             step_dn;
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    step_up = inc & ~dec & (count != CAP_V);
    step_dn = dec & ~inc & (count != '0);
    cnt_en  = step_up | step_dn;
    cnt_nxt = step_up ? count + 1'b1 : count - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      count <= '0;
    else if (cnt_en) count <= cnt_nxt;
  end

  // R2
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CAP_V);

  // R1
  inc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !dec && count < CAP_V) |=> (count == $past(count) + 1'b1));

  // R1
  dec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && count != '0) |=> (count == $past(count) - 1'b1));

  // R4
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && dec) |=> $stable(count));

  // R2
  floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0 && !inc) |=> (count == '0));

endmodule

// File: rtl/occ_bin2dec.sv
`timescale 1ns/1ps
module occ_bin2dec #(
  parameter int CNT_W = 5
) (
  input  logic [CNT_W-1:0] value,
  output logic [3:0]       tens,
  output logic [3:0]       units
);

  localparam int XW = (CNT_W < 8) ? 8 : CNT_W;

  logic [XW-1:0] ext;
  logic [XW-1:0] quot;
  logic [XW-1:0] rem;

  always_comb begin
    ext   = XW'(value);
    quot  = ext / XW'(10);
    rem   = ext - quot * XW'(10);
    tens  = 4'(quot);
    units = 4'(rem);
  end

endmodule

// File: rtl/occ_display.sv
`timescale 1ns/1ps
module occ_display
  import occ_pkg::*;
#(
  parameter int CAPACITY = 25,
  parameter int CNT_W    = $clog2(CAPACITY + 1)
) (
  input  logic [CNT_W-1:0] count,
  output seg_t [5:0]       digits
);

  localparam logic [CNT_W-1:0] CAP_V = CNT_W'(CAPACITY);

  logic [3:0] tens;
  logic [3:0] units;
  logic       is_zero;
  logic       is_full;
  seg_t       units_seg;
  seg_t       tens_seg;

  occ_bin2dec #(.CNT_W(CNT_W)) u_bin2dec (
    .value (count),
    .tens  (tens),
    .units (units)
  );

  always_comb units_seg = digit_glyph(units);

  generate
    if (CAPACITY < 10) begin : g_one_digit
      logic unused_tens;
      always_comb begin
        unused_tens = |tens;
        tens_seg    = GLYPH_BLANK;
      end
    end else begin : g_two_digit
      always_comb tens_seg = (tens == 4'd0) ? GLYPH_BLANK : digit_glyph(tens);
    end
  endgenerate

  always_comb begin
    is_zero = (count == '0);
    is_full = (count == CAP_V);

    digits    = {6{GLYPH_BLANK}};
    digits[1] = tens_seg;
    digits[0] = units_seg;

    if (is_zero) begin
      digits[5] = GLYPH_C;
      digits[4] = GLYPH_L;
      digits[3] = GLYPH_E;
      digits[2] = GLYPH_A;
      digits[1] = GLYPH_R;
    end else if (is_full) begin
      digits[5] = GLYPH_F;
      digits[4] = GLYPH_U;
      digits[3] = GLYPH_L;
      digits[2] = GLYPH_L;
    end
  end

endmodule

// File: rtl/lot_occupancy_display.sv
`timescale 1ns/1ps
module lot_occupancy_display
  import occ_pkg::*;
#(
  parameter int CAPACITY = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       dec,
  input  logic       sens_a,
  input  logic       sens_b,
  output logic [6:0] hex0,
  output logic [6:0] hex1,
  output logic [6:0] hex2,
  output logic [6:0] hex3,
  output logic [6:0] hex4,
  output logic [6:0] hex5,
  output logic       led_left,
  output logic       led_right
);

  localparam int CNT_W = $clog2(CAPACITY + 1);

  logic             rst_sync_n;
  logic [CNT_W-1:0] count;
  seg_t [5:0]       digits;

  occ_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  occ_counter #(.CAPACITY(CAPACITY), .CNT_W(CNT_W)) u_counter (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .inc   (inc),
    .dec   (dec),
    .count (count)
  );

  occ_display #(.CAPACITY(CAPACITY), .CNT_W(CNT_W)) u_display (
    .count  (count),
    .digits (digits)
  );

  assign hex0      = digits[0];
  assign hex1      = digits[1];
  assign hex2      = digits[2];
  assign hex3      = digits[3];
  assign hex4      = digits[4];
  assign hex5      = digits[5];
  assign led_left  = sens_a;
  assign led_right = sens_b;

  // R5
  full_text_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (count == CNT_W'(CAPACITY)) |-> (hex5 == GLYPH_F && hex2 == GLYPH_L));

  // R6
  clear_text_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (count == '0) |-> (hex0 == digit_glyph(4'd0) && hex1 == GLYPH_R));

  // R3
  upper_blank_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (count != '0 && count != CNT_W'(CAPACITY)) |-> (hex5 == GLYPH_BLANK));

endmodule

// File: tb/test_lot_occupancy_display.sv
`timescale 1ns/1ps
module test_lot_occupancy_display;

  localparam int CAP_BIG   = 25;
  localparam int CAP_SMALL = 5;

  logic clk = 1'b0;
  logic rst_n;
  logic inc, dec, sens_a, sens_b;
  logic [6:0] b0, b1, b2, b3, b4, b5;
  logic [6:0] s0, s1, s2, s3, s4, s5;
  logic bl, br, sl, sr;

  int n_total = 0;
  int n_fail  = 0;
  int cnt_big = 0;
  int cnt_small = 0;

  always #2.5 clk = ~clk;

  lot_occupancy_display #(.CAPACITY(CAP_BIG)) i_lot_occupancy_display (
    .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec),
    .sens_a(sens_a), .sens_b(sens_b),
    .hex0(b0), .hex1(b1), .hex2(b2), .hex3(b3), .hex4(b4), .hex5(b5),
    .led_left(bl), .led_right(br)
  );

  lot_occupancy_display #(.CAPACITY(CAP_SMALL)) i_lot_occupancy_display_small (
    .clk(clk), .rst_n(rst_n), .inc(inc), .dec(dec),
    .sens_a(sens_a), .sens_b(sens_b),
    .hex0(s0), .hex1(s1), .hex2(s2), .hex3(s3), .hex4(s4), .hex5(s5),
    .led_left(sl), .led_right(sr)
  );

  function automatic logic [6:0] dg(int d);
    logic [6:0] lit;
    case (d)
      0: lit = 7'h3F; 1: lit = 7'h06; 2: lit = 7'h5B; 3: lit = 7'h4F;
      4: lit = 7'h66; 5: lit = 7'h6D; 6: lit = 7'h7D; 7: lit = 7'h07;
      8: lit = 7'h7F; default: lit = 7'h6F;
    endcase
    return ~lit;
  endfunction

  function automatic logic [41:0] expect_hex(int c, int cap);
    logic [6:0] h [6];
    for (int k = 0; k < 6; k++) h[k] = 7'h7F;
    h[0] = dg(c % 10);
    if (c / 10 != 0) h[1] = dg(c / 10);
    if (c == 0) begin
      h[5] = ~7'h39; h[4] = ~7'h38; h[3] = ~7'h79; h[2] = ~7'h77; h[1] = ~7'h50;
    end else if (c == cap) begin
      h[5] = ~7'h71; h[4] = ~7'h3E; h[3] = ~7'h38; h[2] = ~7'h38;
    end
    return {h[5], h[4], h[3], h[2], h[1], h[0]};
  endfunction

  function automatic int next_count(int c, int cap, bit i, bit d);
    if (i && !d && c < cap) return c + 1;
    if (d && !i && c > 0)   return c - 1;
    return c;
  endfunction

  function automatic string rule_tag(int c, int cap, bit i, bit d);
    if (i && d) return "R4";
    if ((i && c == cap) || (d && c == 0)) return "R2";
    return "R1";
  endfunction

  function automatic string disp_tag(int c, int cap);
    if (c == 0)   return "R6";
    if (c == cap) return "R5";
    return "R3";
  endfunction

  task automatic check(string tag, logic [41:0] act, logic [41:0] exp);
    n_total++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(string big_tag, string small_tag);
    check({big_tag, "/", disp_tag(cnt_big, CAP_BIG), " cap25"},
          {b5, b4, b3, b2, b1, b0}, expect_hex(cnt_big, CAP_BIG));
    check({small_tag, "/", disp_tag(cnt_small, CAP_SMALL), " R9 cap5"},
          {s5, s4, s3, s2, s1, s0}, expect_hex(cnt_small, CAP_SMALL));
    check("R7 leds", 42'({bl, br, sl, sr}), 42'({sens_a, sens_b, sens_a, sens_b}));
  endtask

  task automatic step(bit i, bit d, bit a, bit b);
    string tb, ts;
    @(negedge clk);
    inc = i; dec = d; sens_a = a; sens_b = b;
    #0.5;
    check("R7 leds comb", 42'({bl, br, sl, sr}), 42'({a, b, a, b}));
    @(posedge clk);
    #1;
    tb = rule_tag(cnt_big, CAP_BIG, i, d);
    ts = rule_tag(cnt_small, CAP_SMALL, i, d);
    cnt_big   = next_count(cnt_big, CAP_BIG, i, d);
    cnt_small = next_count(cnt_small, CAP_SMALL, i, d);
    check_all(tb, ts);
  endtask

  task automatic idle(int n);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0; inc = 1'b0; dec = 1'b0;
    #1;
    cnt_big = 0; cnt_small = 0;
    check_all("R8 async", "R8 async");
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
  endtask

  task automatic random_phase(int n, int up_pct);
    for (int k = 0; k < n; k++) begin
      int r;
      bit i, d;
      r = $urandom_range(99);
      i = 1'b0; d = 1'b0;
      if (r < 8) begin i = 1'b1; d = 1'b1; end
      else if (r < 8 + up_pct * 80 / 100) i = 1'b1;
      else if (r < 88) d = 1'b1;
      step(i, d, 1'($urandom_range(1)), 1'($urandom_range(1)));
    end
  endtask

  initial begin
    #(200000 * 5);
    n_total++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    int seed;
    seed = 371;
    void'($urandom(seed));
    rst_n = 1'b0; inc = 1'b0; dec = 1'b0; sens_a = 1'b0; sens_b = 1'b0;
    repeat (3) @(negedge clk);
    check_all("R8 reset", "R8 reset");
    rst_n = 1'b1;
    idle(3);

    // R2: dec at zero leaves count at zero
    step(1'b0, 1'b1, 1'b1, 1'b0);
    // R4: both at zero
    step(1'b1, 1'b1, 1'b0, 1'b1);
    // R1/R3/R5: climb past capacity of both copies
    for (int k = 0; k < 30; k++) step(1'b1, 1'b0, k[0], k[1]);
    // R4 at capacity, R2 clamp
    step(1'b1, 1'b1, 1'b1, 1'b1);
    step(1'b1, 1'b0, 1'b0, 1'b0);
    // R1: descend to zero and beyond
    for (int k = 0; k < 30; k++) step(1'b0, 1'b1, k[1], k[0]);
    // R4 mid-range
    for (int k = 0; k < 12; k++) step(1'b1, 1'b0, 1'b0, 1'b0);
    step(1'b1, 1'b1, 1'b0, 1'b0);

    random_phase(200, 85);
    random_phase(200, 15);
    random_phase(150, 50);

    // R8: reset from mid-count, display clears without a clock edge
    for (int k = 0; k < 7; k++) step(1'b1, 1'b0, 1'b0, 1'b0);
    apply_reset();
    random_phase(200, 90);
    random_phase(100, 50);

    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule